// File: doc/BRIEF.md
# Memory Read Traffic Checker

This block generates read traffic on a memory-mapped master port and verifies the data that comes back. Software programs a base address, a transfer count with a mode bit, and a control word holding an enable bit and a burst length. Once enabled, the block issues one burst read at a time. The first burst starts at the base address, and each later burst starts right after the previous one. Every returned beat is compared against an incrementing 32-bit word pattern.

Two counters report activity since they were last read: one for completed transfers and one for mismatching beats. Both clear when read and saturate instead of wrapping. In fixed mode the block runs the programmed number of transfers and then clears its own enable bit. In non-stop mode it keeps issuing bursts until software clears the enable bit, and the burst in flight is always allowed to finish. Address translation and the link layer sit outside this block.

The register slave has a 32-bit data path with registers spaced eight bytes apart. Read data appears on `reg_rdata` one cycle after `reg_rd` is asserted.

Top module: `rd_traffic_checker`

## Requirements
- R1: After reset, all four registers read 0 and `mem_rd` stays low.
- R2: The register at offset 0x00 holds the 32-bit base address and reads back exactly what was written.
- R3: The first burst request after a start carries the base address. Each later request carries the previous address plus burst length × 8 bytes. Every request's `mem_burst` equals the programmed burst length. A request waits while `mem_wait` is high, with address and burst length held.
- R4: The expected data for beat g (counted from 0 since the start) is, in 32-bit lane i (bits 32i+31:32i), the base address + 2g + i. A beat with any mismatching lane adds exactly one to the error count at offset 0x10, bits [11:0], no matter how many lanes differ.
- R5: When bit 31 of offset 0x08 is 0 (fixed mode), the block runs exactly as many bursts as bits [11:0] of 0x08 specify. It then clears the enable bit (bit 31 of 0x18) by itself.
- R6: When bit 31 of 0x08 is 1 (non-stop mode), bursts continue past the programmed count until software writes enable 0. Every burst that was issued still delivers all its beats.
- R7: A read of 0x08 returns the mode in bit 31 and, in bits [11:0], the number of transfers completed since the previous read of 0x08, then clears that number. A transfer that completes in the same cycle as the read is counted in the next period.
- R8: A read of 0x10 clears the error count.
- R9: The transfer count and the error count stop at 0xFFF and do not wrap.
- R10: A start request is refused, and enable reads back 0 with no burst issued, if the burst length field (bits [7:0] of 0x18) is 0. It is also refused in fixed mode when the programmed count is 0.
- R11: The burst length written to 0x18 bits [7:0] reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| mem_rd | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst start byte address |
| mem_burst | output | 8 | Beats in the requested burst |
| mem_wait | input | 1 | Stall: request not taken this cycle |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 64 | Read data beat |

## Verification
The bench builds the block with its default parameters: a 64-bit data bus (two pattern lanes, 8-byte address step), 12-bit counters and an 8-bit burst length. The 12-bit counters let a single-beat non-stop run push both counters into saturation within about nine thousand cycles. The narrow bus makes it possible to sweep every pairing of burst lengths 1 to 6 with fixed counts 1 to 4, with and without stalls on the request port. Single-lane and all-lane corruptions confirm that each bad beat counts once, and uninterrupted back-to-back reads of the transfer count show that no completion is lost when a read coincides with it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW = 8;
  localparam int REG_W  = 32;
  localparam int HI_BIT = 31;   // mode bit of the count register, enable bit of control

  localparam logic [REG_AW-1:0] OFS_BASE = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CNT  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_ERR  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CTL  = 8'h18;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_DATA = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rtc_satcnt.sv
// Saturating event counter, cleared by a read strobe; an event coincident
// with the clear becomes the first event of the new period.
module rtc_satcnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (clr)
      q <= inc ? W'(1) : '0;
    else if (inc && (q != {W{1'b1}}))
      q <= q + 1'b1;
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs import rtc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int BLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              xfer_inc,
  input  logic              err_inc,
  input  logic              auto_stop,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  target_q,
  output logic              mode_q,
  output logic              enable_q,
  output logic [BLEN_W-1:0] blen_q,
  output logic [CNT_W-1:0]  xfer_q,
  output logic [CNT_W-1:0]  err_q,
  output logic              xfer_clr,
  output logic              err_clr
);
  logic [REG_W-1:0] rd_next;
  logic             start_ok;

  assign xfer_clr = reg_rd && (reg_addr == OFS_CNT);
  assign err_clr  = reg_rd && (reg_addr == OFS_ERR);

  // a start needs a nonzero burst length, and a nonzero count unless non-stop
  assign start_ok = reg_wdata[HI_BIT] && (reg_wdata[BLEN_W-1:0] != '0) &&
                    (mode_q || (target_q != '0));

  rtc_satcnt #(.W(CNT_W)) u_xfer_cnt (
    .clk(clk), .rst(rst), .inc(xfer_inc), .clr(xfer_clr), .q(xfer_q)
  );
  rtc_satcnt #(.W(CNT_W)) u_err_cnt (
    .clk(clk), .rst(rst), .inc(err_inc), .clr(err_clr), .q(err_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      target_q <= '0;
      mode_q   <= 1'b0;
      enable_q <= 1'b0;
      blen_q   <= '0;
    end else begin
      if (auto_stop)
        enable_q <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          OFS_BASE: base_q <= reg_wdata[ADDR_W-1:0];
          OFS_CNT: begin
            target_q <= reg_wdata[CNT_W-1:0];
            mode_q   <= reg_wdata[HI_BIT];
          end
          OFS_CTL: begin
            blen_q   <= reg_wdata[BLEN_W-1:0];
            enable_q <= start_ok;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      OFS_BASE: rd_next[ADDR_W-1:0] = base_q;
      OFS_CNT: begin
        rd_next[CNT_W-1:0] = xfer_q;
        rd_next[HI_BIT]    = mode_q;
      end
      OFS_ERR: rd_next[CNT_W-1:0] = err_q;
      OFS_CTL: begin
        rd_next[BLEN_W-1:0] = blen_q;
        rd_next[HI_BIT]     = enable_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_next;
  end
endmodule

// File: rtl/rtc_seq.sv
module rtc_seq import rtc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int BLEN_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mode,
  input  logic [CNT_W-1:0]  target,
  input  logic [ADDR_W-1:0] base,
  input  logic [BLEN_W-1:0] blen,
  input  logic              mem_wait,
  input  logic              mem_rvalid,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLEN_W-1:0] mem_burst,
  output logic              start,
  output logic              beat_acc,
  output logic              xfer_done,
  output logic              auto_stop
);
  localparam int BYTES = DATA_W / 8;

  seq_state_t        state_q;
  logic [BLEN_W-1:0] beat_q;
  logic [CNT_W-1:0]  rem_q;
  logic              run_mode_q;
  logic              last_beat;
  logic              count_hit;

  assign mem_rd    = (state_q == S_REQ);
  assign start     = (state_q == S_IDLE) && enable;
  assign beat_acc  = (state_q == S_DATA) && mem_rvalid;
  assign last_beat = beat_acc && (beat_q == mem_burst - 1'b1);
  assign count_hit = !run_mode_q && (rem_q == CNT_W'(1));
  assign xfer_done = last_beat;
  assign auto_stop = last_beat && count_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      beat_q     <= '0;
      rem_q      <= '0;
      run_mode_q <= 1'b0;
      mem_addr   <= '0;
      mem_burst  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (enable) begin
          mem_addr   <= base;
          mem_burst  <= blen;
          rem_q      <= target;
          run_mode_q <= mode;
          beat_q     <= '0;
          state_q    <= S_REQ;
        end
        S_REQ: if (!mem_wait) state_q <= S_DATA;
        S_DATA: if (beat_acc) begin
          if (last_beat) begin
            beat_q <= '0;
            if (!run_mode_q) rem_q <= rem_q - 1'b1;
            if (count_hit || !enable) begin
              state_q <= S_IDLE;
            end else begin
              mem_addr <= mem_addr + ADDR_W'(mem_burst) * ADDR_W'(BYTES);
              state_q  <= S_REQ;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_cmp.sv
module rtc_cmp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       seed,
  input  logic              beat_acc,
  input  logic [DATA_W-1:0] rdata,
  output logic              err_pulse
);
  localparam int LANES = DATA_W / 32;

  logic [31:0]      exp_q;
  logic [LANES-1:0] miss;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign miss[i] = rdata[32*i +: 32] != (exp_q + 32'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q     <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= beat_acc && (|miss);
      if (start)
        exp_q <= seed;
      else if (beat_acc)
        exp_q <= exp_q + 32'(LANES);
    end
  end
endmodule

// File: rtl/rd_traffic_checker.sv
module rd_traffic_checker import rtc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 12,
  parameter int BLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLEN_W-1:0] mem_burst,
  input  logic              mem_wait,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  target_q, xfer_q, err_q;
  logic              mode_q, enable_q, xfer_clr, err_clr;
  logic [BLEN_W-1:0] blen_q;
  logic              start, beat_acc, xfer_inc, auto_stop, err_inc;

  rtc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLEN_W(BLEN_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_inc(xfer_inc),
    .err_inc(err_inc), .auto_stop(auto_stop), .base_q(base_q), .target_q(target_q),
    .mode_q(mode_q), .enable_q(enable_q), .blen_q(blen_q), .xfer_q(xfer_q),
    .err_q(err_q), .xfer_clr(xfer_clr), .err_clr(err_clr)
  );

  rtc_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLEN_W(BLEN_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .enable(enable_q), .mode(mode_q), .target(target_q),
    .base(base_q), .blen(blen_q), .mem_wait(mem_wait), .mem_rvalid(mem_rvalid),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_burst(mem_burst), .start(start),
    .beat_acc(beat_acc), .xfer_done(xfer_inc), .auto_stop(auto_stop)
  );

  rtc_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .start(start), .seed(base_q[31:0]), .beat_acc(beat_acc),
    .rdata(mem_rdata), .err_pulse(err_inc)
  );
endmodule

// File: rtl/rd_traffic_checker_chk.sv
module rd_traffic_checker_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int BLEN_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wait,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BLEN_W-1:0] mem_burst,
  input logic              enable_q,
  input logic [BLEN_W-1:0] blen_q,
  input logic [CNT_W-1:0]  xfer_q,
  input logic              xfer_inc,
  input logic              xfer_clr,
  input logic [CNT_W-1:0]  err_q,
  input logic              err_inc,
  input logic              err_clr
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr) && $stable(mem_burst)));

  // R3
  burst_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_burst != '0));

  // R10
  enable_len_chk: assert property (@(posedge clk) disable iff (rst)
    enable_q |-> (blen_q != '0));

  // R9
  xfer_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ((xfer_q == {CNT_W{1'b1}}) && !xfer_clr) |=> (xfer_q == {CNT_W{1'b1}}));

  // R7
  keep_event_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_clr && xfer_inc) |=> (xfer_q == CNT_W'(1)));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !err_inc) |=> (err_q == '0));

  // R4
  err_step_chk: assert property (@(posedge clk) disable iff (rst)
    !err_clr |=> ((err_q == $past(err_q)) || (err_q == $past(err_q) + 1'b1)));
endmodule

bind rd_traffic_checker rd_traffic_checker_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLEN_W(BLEN_W)
) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wait(mem_wait), .mem_addr(mem_addr),
  .mem_burst(mem_burst), .enable_q(enable_q), .blen_q(blen_q), .xfer_q(xfer_q),
  .xfer_inc(xfer_inc), .xfer_clr(xfer_clr), .err_q(err_q), .err_inc(err_inc),
  .err_clr(err_clr)
);

// File: tb/rd_traffic_checker_tb_top.sv
module rd_traffic_checker_tb_top;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 32;
  localparam int BYTES  = DATA_W / 8;
  localparam logic [7:0] A_BASE = 8'h00, A_CNT = 8'h08, A_ERR = 8'h10, A_CTL = 8'h18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [7:0]  mem_burst;
  logic        mem_wait = 0, mem_rvalid = 0;
  logic [DATA_W-1:0] mem_rdata = '0;

  rd_traffic_checker dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_burst(mem_burst), .mem_wait(mem_wait), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  int n_tests = 0, n_fail = 0;
  // memory responder state
  int r_left = 0, gb = 0, run_k = 0, blen_cur = 1, cyc = 0;
  int bursts_req = 0, bursts_done = 0, addr_bad = 0;
  int bad1 = -1, bad2 = -1;
  bit wait_en = 0, corrupt_all = 0;
  logic [31:0] cur_base = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // Memory model: takes a request when mem_rd && !mem_wait, then returns one
  // beat per cycle carrying the pattern word base + 2g + lane.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_wait   = wait_en && (cyc % 3 == 0);
      mem_rvalid = 0;
      if (r_left > 0) begin
        logic [DATA_W-1:0] d;
        for (int i = 0; i < LANES; i++)
          d[32*i +: 32] = cur_base + 32'(gb * LANES + i);
        if (corrupt_all || gb == bad1) d[0] = ~d[0];
        if (gb == bad2) d = ~d;
        mem_rdata  = d;
        mem_rvalid = 1;
        gb++;
        r_left--;
        if (r_left == 0) bursts_done++;
      end else if (mem_rd && !mem_wait) begin
        if (mem_addr != cur_base + 32'(run_k * blen_cur * BYTES) ||
            mem_burst != 8'(blen_cur))
          addr_bad++;
        run_k++;
        r_left = int'(mem_burst);
        bursts_req++;
      end
    end
  end

  task automatic setup_run(input int bl, input logic [31:0] base);
    cur_base = base; blen_cur = bl; run_k = 0; gb = 0;
  endtask

  task automatic run_fixed(input int bl, input int cnt, input logic [31:0] base,
                           input int exp_err);
    logic [31:0] d;
    int d0, a0, polls;
    setup_run(bl, base);
    d0 = bursts_done; a0 = addr_bad;
    wr(A_BASE, base);
    wr(A_CNT, 32'(cnt));
    wr(A_CTL, 32'h8000_0000 | 32'(bl));
    polls = 0;
    do begin rd(A_CTL, d); polls++; end while (d[31] && polls < 500);
    chk("R5 enable cleared after fixed count", d, 32'(bl));
    repeat (4) @(negedge clk);
    rd(A_CNT, d);  chk("R7 transfers since last read", d, 32'(cnt));
    rd(A_ERR, d);  chk("R4 error count", d, 32'(exp_err));
    rd(A_CNT, d);  chk("R7 count cleared by read", d, 32'h0);
    rd(A_ERR, d);  chk("R8 errors cleared by read", d, 32'h0);
    chk("R5 bursts run", 32'(bursts_done - d0), 32'(cnt));
    chk("R3 burst address and length", 32'(addr_bad - a0), 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    int d0, q0, sum;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(A_BASE, d); chk("R1 base after reset", d, 0);
    rd(A_CNT, d);  chk("R1 count after reset", d, 0);
    rd(A_ERR, d);  chk("R1 errors after reset", d, 0);
    rd(A_CTL, d);  chk("R1 control after reset", d, 0);
    chk("R1 no request after reset", 32'(mem_rd), 0);

    // R2 base readback
    wr(A_BASE, 32'hDEAD_BEE8); rd(A_BASE, d); chk("R2 base readback", d, 32'hDEAD_BEE8);
    // R11 burst length readback
    wr(A_CTL, 32'h0000_00A5); rd(A_CTL, d); chk("R11 burst length readback", d, 32'hA5);

    // R10 refusal cases
    q0 = bursts_req;
    wr(A_CNT, 32'd3);
    wr(A_CTL, 32'h8000_0000);
    rd(A_CTL, d); chk("R10 zero burst length refused", d, 0);
    wr(A_CNT, 32'd0);
    wr(A_CTL, 32'h8000_0004);
    rd(A_CTL, d); chk("R10 zero fixed count refused", d, 32'h4);
    repeat (20) @(negedge clk);
    chk("R10 no burst issued", 32'(bursts_req - q0), 0);

    // R3 R4 R5 R7 R8 sweep
    for (int bl = 1; bl <= 6; bl++)
      for (int c = 1; c <= 4; c++) begin
        wait_en = ((bl + c) % 2) == 1;
        run_fixed(bl, c, 32'h0001_0000 * bl + 32'h100 * c, 0);
      end
    wait_en = 0;

    // R4 one lane bad in beat 2, all lanes bad in beat 5: two errors
    bad1 = 2; bad2 = 5;
    run_fixed(4, 2, 32'h0BAD_0000, 2);
    bad1 = -1; bad2 = -1;

    // R6 non-stop runs past the programmed count, in-flight burst completes
    setup_run(3, 32'h0040_0000);
    d0 = bursts_done;
    wr(A_BASE, 32'h0040_0000);
    wr(A_CNT, 32'h8000_0005);
    wr(A_CTL, 32'h8000_0003);
    repeat (200) @(negedge clk);
    wr(A_CTL, 32'h0000_0003);
    repeat (40) @(negedge clk);
    chk("R6 all issued bursts completed", 32'(bursts_done), 32'(bursts_req));
    chk("R6 ran past count", 32'(bursts_done - d0 > 5), 1);
    rd(A_CNT, d); chk("R6 count with mode bit", d, 32'h8000_0000 | 32'(bursts_done - d0));
    chk("R3 non-stop addresses", 32'(addr_bad), 0);

    // R7 back-to-back reads lose no completions
    setup_run(1, 32'h0050_0000);
    d0 = bursts_done;
    wr(A_BASE, 32'h0050_0000);
    wr(A_CTL, 32'h8000_0001);
    sum = 0;
    @(negedge clk); reg_rd = 1; reg_addr = A_CNT;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      sum += int'(reg_rdata[11:0]);
    end
    reg_rd = 0;
    wr(A_CTL, 32'h0000_0001);
    repeat (10) @(negedge clk);
    rd(A_CNT, d);
    sum += int'(d[11:0]);
    chk("R7 summed reads equal completions", 32'(sum), 32'(bursts_done - d0));

    // R9 saturation of both counters
    setup_run(1, 32'h0060_0000);
    corrupt_all = 1;
    d0 = bursts_done;
    wr(A_BASE, 32'h0060_0000);
    wr(A_CTL, 32'h8000_0001);
    for (int k = 0; k < 20000 && (bursts_done - d0) < 4200; k++) @(negedge clk);
    wr(A_CTL, 32'h0000_0001);
    repeat (10) @(negedge clk);
    corrupt_all = 0;
    rd(A_CNT, d); chk("R9 transfer count saturated", d, 32'h8000_0FFF);
    rd(A_ERR, d); chk("R9 error count saturated", d, 32'h0000_0FFF);
    rd(A_CNT, d); chk("R7 cleared after saturation", d, 32'h8000_0000);
    rd(A_ERR, d); chk("R8 cleared after saturation", d, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule